// File: doc/BRIEF.md
# Input Capture Event Generator

This block watches one asynchronous input pin and turns its transitions into capture events. On each qualifying event it raises a one-cycle capture strobe and presents the value of one of two free-running 16-bit timers, so a downstream buffer can store it. The timers, the storage behind the strobe and any register access sit outside the block.

A 3-bit mode field picks the qualifying events:

| Mode | Behaviour |
|------|-----------|
| 000 | off |
| 001 | every transition |
| 010 | falling transitions only |
| 011 | rising transitions only |
| 100 | every 4th rising transition |
| 101 | every 16th rising transition |
| 110 | disabled |
| 111 | interrupt only: a rising transition raises a request and captures nothing |

The divided modes use a prescale counter. The counter keeps its residue when software moves straight from one active mode to another. It is cleared only by reset or by passing through mode 000.

Two power inputs gate the block. Sleep stops every capture mode. Idle stops every capture mode when the idle-stop control is set. In both cases the interrupt-only mode keeps working, so the pin can still wake the system.

Top module: `capture_event_gen`

## Requirements
- R1: After reset, `cap_valid` and `irq_ext` are low and the prescale count is zero. A reset in the middle of a divided mode discards the counted edges, so the next strobe needs a full 4 edges.
- R2: In mode 001, a strobe follows both rising and falling pin transitions. The strobe appears 1 to 2 clock cycles after the pin changes, through a two-flop synchronizer and an edge register.
- R3: In mode 010 only falling transitions strobe. In mode 011 only rising transitions strobe.
- R4: While `cap_valid` is high, `cap_value` equals `timer_a` when `timer_sel` is 1 and `timer_b` when `timer_sel` is 0, taken in the strobe cycle.
- R5: In mode 100 the strobe fires on every 4th rising transition counted since the count was last cleared. Falling transitions are ignored.
- R6: In mode 101 the strobe fires on every 16th rising transition counted since the count was last cleared.
- R7: Switching directly between active modes keeps the residual count, so the next capture can come early. Passing through mode 000 clears the count.
- R8: In mode 111 each rising transition pulses `irq_ext` and never `cap_valid`. A falling transition produces nothing.
- R9: Modes 000 and 110 produce neither `cap_valid` nor `irq_ext`.
- R10: While `sleep_req` is high, only mode 111 produces output. The prescale count does not advance.
- R11: With `idle_stop` and `idle_req` both high, only mode 111 produces output. With `idle_stop` low, every mode works during idle.
- R12: `cap_valid` is only ever high in a cycle where a synchronized transition is seen. `cap_valid` and `irq_ext` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_async | input | 1 | Asynchronous input pin |
| mode_sel | input | 3 | Event mode (encoding in the mode table) |
| timer_sel | input | 1 | 1 selects `timer_a`, 0 selects `timer_b` |
| timer_a | input | 16 | First free-running timer value |
| timer_b | input | 16 | Second free-running timer value |
| idle_stop | input | 1 | Stop capture modes during idle |
| idle_req | input | 1 | System is in idle |
| sleep_req | input | 1 | System is in sleep |
| cap_valid | output | 1 | Capture strobe, one cycle per event |
| cap_value | output | 16 | Selected timer value while `cap_valid` is high |
| irq_ext | output | 1 | Interrupt-only request pulse (mode 111) |

## Verification
Each mode is driven with the same alternating rise/fall pin pattern, so the bench can tell which transition directions each mode accepts. The timer select is flipped between strobes so that a swapped timer is caught.

The divided modes are driven with long runs of rising edges:
- Straight after another divided mode, which shows that the residue is kept.
- After a pass through mode 000, which shows that the count is cleared.
- Across a sleep window, which shows that the count is frozen.
- Across a reset, which shows that the count is discarded.

The same pin patterns are repeated under sleep, idle with idle-stop, and idle without idle-stop. This separates the interrupt-only path, which must survive the gating, from the capture paths, which must stop.

// File: rtl/cap_pkg.sv
package cap_pkg;

  // Bits in the prescale counter: enough for the largest division (16)
  localparam int PSCL_W = 4;
  // Low counter bits that define the divide-by-4 wrap
  localparam int DIV4_BITS = 2;

  typedef enum logic [2:0] {
    CM_OFF   = 3'b000,
    CM_BOTH  = 3'b001,
    CM_FALL  = 3'b010,
    CM_RISE  = 3'b011,
    CM_DIV4  = 3'b100,
    CM_DIV16 = 3'b101,
    CM_RSVD  = 3'b110,
    CM_IRQ   = 3'b111
  } cap_mode_e;

  // True when the next counted rising edge completes a division period
  function automatic logic pscl_at_wrap(cap_mode_e m, logic [PSCL_W-1:0] cnt);
    case (m)
      CM_DIV4:  return &cnt[DIV4_BITS-1:0];
      CM_DIV16: return &cnt;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic is_divided(cap_mode_e m);
    return (m == CM_DIV4) || (m == CM_DIV16);
  endfunction

  // Capture modes stop during sleep, and during idle when idle-stop is set
  function automatic logic capture_allowed(logic sleep, logic idle, logic stop);
    return !sleep && !(idle && stop);
  endfunction

endpackage

// File: rtl/cap_pin_sync.sv
module cap_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES-1];
  end

  assign rise_o =  chain[STAGES-1] && !prev_q;
  assign fall_o = !chain[STAGES-1] &&  prev_q;

endmodule

// File: rtl/cap_prescaler.sv
module cap_prescaler
  import cap_pkg::*;
#(
  parameter int W = PSCL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/cap_event_sel.sv
module cap_event_sel
  import cap_pkg::*;
(
  input  cap_mode_e mode_i,
  input  logic      rise_i,
  input  logic      fall_i,
  input  logic      run_i,
  input  logic      wrap_i,
  output logic      cap_fire_o,
  output logic      irq_fire_o,
  output logic      pscl_step_o
);

  always_comb begin
    cap_fire_o  = 1'b0;
    irq_fire_o  = 1'b0;
    pscl_step_o = 1'b0;
    case (mode_i)
      CM_BOTH: cap_fire_o = run_i && (rise_i || fall_i);
      CM_FALL: cap_fire_o = run_i && fall_i;
      CM_RISE: cap_fire_o = run_i && rise_i;
      CM_DIV4, CM_DIV16: begin
        pscl_step_o = run_i && rise_i;
        cap_fire_o  = run_i && rise_i && wrap_i;
      end
      CM_IRQ:  irq_fire_o = rise_i;
      default: ;
    endcase
  end

endmodule

// File: rtl/capture_event_gen.sv
module capture_event_gen
  import cap_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_async,
  input  logic [2:0]    mode_sel,
  input  logic          timer_sel,
  input  logic [TW-1:0] timer_a,
  input  logic [TW-1:0] timer_b,
  input  logic          idle_stop,
  input  logic          idle_req,
  input  logic          sleep_req,
  output logic          cap_valid,
  output logic [TW-1:0] cap_value,
  output logic          irq_ext
);

  cap_mode_e         mode;
  logic              rise_evt;
  logic              fall_evt;
  logic              cap_run;
  logic              pscl_wrap;
  logic              pscl_step;
  logic              pscl_clear;
  logic [PSCL_W-1:0] pscl_cnt;

  assign mode       = cap_mode_e'(mode_sel);
  assign cap_run    = capture_allowed(sleep_req, idle_req, idle_stop);
  assign pscl_clear = (mode == CM_OFF);
  assign pscl_wrap  = pscl_at_wrap(mode, pscl_cnt);

  cap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (pin_async),
    .rise_o    (rise_evt),
    .fall_o    (fall_evt)
  );

  cap_prescaler #(.W(PSCL_W)) u_pscl (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (pscl_clear),
    .step_i  (pscl_step),
    .cnt_o   (pscl_cnt)
  );

  cap_event_sel u_sel (
    .mode_i      (mode),
    .rise_i      (rise_evt),
    .fall_i      (fall_evt),
    .run_i       (cap_run),
    .wrap_i      (pscl_wrap),
    .cap_fire_o  (cap_valid),
    .irq_fire_o  (irq_ext),
    .pscl_step_o (pscl_step)
  );

  assign cap_value = timer_sel ? timer_a : timer_b;

endmodule

// File: rtl/cap_event_chk.sv
module cap_event_chk #(
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode_sel,
  input logic          sleep_req,
  input logic          idle_req,
  input logic          idle_stop,
  input logic          rise_evt,
  input logic          fall_evt,
  input logic [PW-1:0] pscl_cnt,
  input logic          cap_valid,
  input logic          irq_ext
);

  // R12
  strobe_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> (rise_evt || fall_evt));

  // R12
  no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_valid && irq_ext));

  // R9
  quiet_modes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'b000 || mode_sel == 3'b110) |-> (!cap_valid && !irq_ext));

  // R3
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && mode_sel == 3'b011) |-> rise_evt);

  // R8
  irq_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ext |-> (mode_sel == 3'b111 && rise_evt));

  // R7
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'b000) |=> (pscl_cnt == '0));

  // R10
  sleep_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> !cap_valid);

  // R10
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && mode_sel != 3'b000) |=> $stable(pscl_cnt));

  // R11
  idle_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && idle_stop) |-> !cap_valid);

endmodule

bind capture_event_gen cap_event_chk #(.PW(cap_pkg::PSCL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .sleep_req (sleep_req),
  .idle_req  (idle_req),
  .idle_stop (idle_stop),
  .rise_evt  (rise_evt),
  .fall_evt  (fall_evt),
  .pscl_cnt  (pscl_cnt),
  .cap_valid (cap_valid),
  .irq_ext   (irq_ext)
);

// File: tb/capture_event_gen_tb.sv
`timescale 1ns/1ps
module capture_event_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pin_async;
  logic [2:0]  mode_sel;
  logic        timer_sel;
  logic [15:0] timer_a;
  logic [15:0] timer_b;
  logic        idle_stop;
  logic        idle_req;
  logic        sleep_req;
  logic        cap_valid;
  logic [15:0] cap_value;
  logic        irq_ext;

  int n_chk  = 0;
  int n_fail = 0;
  int stamp  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  capture_event_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (pin_async),
    .mode_sel  (mode_sel),
    .timer_sel (timer_sel),
    .timer_a   (timer_a),
    .timer_b   (timer_b),
    .idle_stop (idle_stop),
    .idle_req  (idle_req),
    .sleep_req (sleep_req),
    .cap_valid (cap_valid),
    .cap_value (cap_value),
    .irq_ext   (irq_ext)
  );

  // Vector fields: {mode[9:7], tsel[6], stop[5], idle[4], sleep[3], pin[2], exp_valid[1], exp_irq[0]}
  localparam int NV = 32;
  localparam logic [9:0] VEC [NV] = '{
    10'b001_1_000_1_10, 10'b001_0_000_0_10,   // R2 both edges, R4 timer flip
    10'b010_1_000_1_00, 10'b010_1_000_0_10,   // R3 falling only
    10'b011_0_000_1_10, 10'b011_0_000_0_00,   // R3 rising only
    10'b000_0_000_1_00, 10'b000_0_000_0_00,   // R9 off
    10'b110_0_000_1_00, 10'b110_0_000_0_00,   // R9 disabled
    10'b100_1_000_1_00, 10'b100_1_000_0_00,   // R5 divide by 4
    10'b100_1_000_1_00, 10'b100_1_000_0_00,
    10'b100_1_000_1_00, 10'b100_1_000_0_00,
    10'b100_0_000_1_10, 10'b100_0_000_0_00,
    10'b100_0_000_1_00, 10'b100_0_000_0_00,
    10'b111_0_000_1_01, 10'b111_0_000_0_00,   // R8 interrupt only
    10'b111_0_001_1_01, 10'b111_0_001_0_00,   // R10 sleep keeps 111
    10'b001_0_001_1_00, 10'b001_0_001_0_00,   // R10 sleep stops captures
    10'b011_1_110_1_00, 10'b011_1_110_0_00,   // R11 idle with stop
    10'b011_1_010_1_10, 10'b011_1_010_0_00,   // R11 idle without stop
    10'b111_1_110_1_01, 10'b111_1_110_0_00    // R11 idle with stop keeps 111
  };

  function automatic string vec_req(int i);
    if (i < 2)  return "R2";
    if (i < 6)  return "R3";
    if (i < 10) return "R9";
    if (i < 20) return "R5";
    if (i < 22) return "R8";
    if (i < 26) return "R10";
    return "R11";
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive the pin on a falling clock edge and sample two falling edges later.
  // The third falling edge lets the strobe clear before the next step.
  task automatic step(logic pin, logic ev, logic ei, string req);
    logic [15:0] want;
    stamp++;
    timer_a   = 16'hA000 | 16'(stamp);
    timer_b   = 16'h5000 | 16'(stamp);
    pin_async = pin;
    @(negedge clk);
    @(negedge clk);
    want = timer_sel ? timer_a : timer_b;
    check(req, cap_valid, ev);
    check(req, irq_ext, ei);
    if (ev && cap_valid) check("R4", cap_value, want);
    @(negedge clk);
  endtask

  task automatic rise_pulse(logic ev, string req);
    step(1'b1, ev, 1'b0, req);
    step(1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic set_cfg(logic [2:0] m, logic sl);
    mode_sel  = m;
    sleep_req = sl;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pin_async = 1'b0;
    mode_sel = 3'b000;
    timer_sel = 1'b1;
    timer_a = 16'h0;
    timer_b = 16'h0;
    idle_stop = 1'b0;
    idle_req = 1'b0;
    sleep_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1 outputs low in reset
    check("R1", cap_valid, 0);
    check("R1", irq_ext, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      mode_sel  = VEC[i][9:7];
      timer_sel = VEC[i][6];
      idle_stop = VEC[i][5];
      idle_req  = VEC[i][4];
      sleep_req = VEC[i][3];
      step(VEC[i][2], VEC[i][1], VEC[i][0], vec_req(i));
    end
    idle_stop = 1'b0;
    idle_req  = 1'b0;
    sleep_req = 1'b0;

    // R7 residue: count is 5 from the divide-by-4 run, move straight to 101
    set_cfg(3'b101, 1'b0);
    for (int k = 0; k < 10; k++) rise_pulse(1'b0, "R7");
    rise_pulse(1'b1, "R7");

    // R6 full divide-by-16 from a wrapped count
    for (int k = 0; k < 15; k++) rise_pulse(1'b0, "R6");
    rise_pulse(1'b1, "R6");

    // R7 pass through off clears the residue
    set_cfg(3'b100, 1'b0);
    rise_pulse(1'b0, "R7");
    rise_pulse(1'b0, "R7");
    set_cfg(3'b000, 1'b0);
    step(1'b0, 1'b0, 1'b0, "R7");
    set_cfg(3'b100, 1'b0);
    for (int k = 0; k < 3; k++) rise_pulse(1'b0, "R7");
    rise_pulse(1'b1, "R7");

    // R10 count frozen in sleep: count 4 -> 6, three edges asleep, then 7 fires
    rise_pulse(1'b0, "R10");
    rise_pulse(1'b0, "R10");
    set_cfg(3'b100, 1'b1);
    for (int k = 0; k < 3; k++) rise_pulse(1'b0, "R10");
    set_cfg(3'b100, 1'b0);
    rise_pulse(1'b0, "R10");
    rise_pulse(1'b1, "R10");

    // R1 reset mid-count discards edges
    set_cfg(3'b100, 1'b0);
    rise_pulse(1'b0, "R1");
    rise_pulse(1'b0, "R1");
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", cap_valid, 0);
    check("R1", irq_ext, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 3; k++) rise_pulse(1'b0, "R1");
    rise_pulse(1'b1, "R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule